// File: doc/BRIEF.md
# In-band End-of-Packet Escape Decoder

This block sits on a 64-bit valid/ready word stream that carries no sideband end-of-packet bit. The upstream side marks packet ends in-band. A reserved escape word is followed by a control word and then the payload word it qualifies. The decoder removes the escape and control words and forwards the payload word. It raises an end-of-packet flag on that word when bit 0 of the control word is set. The same escape sequence also carries a data word that happens to equal the escape value, so such data is restored as ordinary output.

On every end-of-packet word the decoder compares the checksum in the control word with a checksum of its own. Its own checksum is a 32-bit wrapping sum of both 32-bit halves of each payload word that came before the last word of the packet. A mismatch is flagged on the last output beat. Backpressure works on both sides. A synchronous clear has the same effect on the decoder as reset.

Top module: `esc_tlast_decoder`

## Requirements
- R1: After reset, or after a cycle with `clr` high, the decoder is in pass-through: `out_valid` is low while `in_valid` is low, and the running checksum is zero.
- R2: In pass-through, a word that is not the escape value 0xDEADBEEFFEEDCAFE is forwarded unchanged with `out_last` low.
- R3: An escape word seen in pass-through, and the control word that follows it, are each accepted with `in_ready` high and `out_valid` low.
- R4: The word after a control word is forwarded unchanged, with `out_last` equal to bit 0 of that control word.
- R5: An escape-valued payload word after a control word is output as data 0xDEADBEEFFEEDCAFE, with `out_last` from control bit 0, and is not taken as a new escape.
- R6: While a word is being offered on the output, `in_ready` equals `out_ready`. A stalled output beat keeps `out_valid`, `out_data` and `out_last` unchanged until it is accepted.
- R7: On an output beat with `out_last` high, `out_sum_err` is high exactly when control bits 63:32 differ from the wrapping 32-bit sum of bits 31:0 plus bits 63:32 over every earlier payload word of the packet. The flag is low on all other beats.
- R8: The running checksum restarts at zero after each accepted last word.
- R9: A clear that comes between an escape word and its control word discards the partial sequence. The next word is treated as pass-through data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear, active high |
| in_data | input | 64 | Encoded input word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Decoder accepts the input word |
| out_data | output | 64 | Decoded data word |
| out_last | output | 1 | Decoded word ends a packet |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_sum_err | output | 1 | Checksum mismatch on the last beat |

## Verification
The stall property assumes that the upstream side follows valid/ready rules: once `in_valid` rises, the word and the valid stay unchanged until `in_ready` takes them. The property also assumes that `clr` does not arrive during a stall. The bench driver holds each offered word until it is accepted and never raises `clr` in the random phase. The properties also assume the input carries well-formed escape sequences. The random encoder in the bench produces only such sequences, and about a quarter of its last words carry a deliberately corrupted checksum.

// File: rtl/esc_dec_pkg.sv
// Shared types for the in-band end-of-packet escape decoder.
package esc_dec_pkg;
    // Decoder position within an escape sequence.
    typedef enum logic [1:0] {
        ST_PASS = 2'd0,   // plain data flows through
        ST_CTRL = 2'd1,   // escape taken, control word expected
        ST_LOAD = 2'd2    // control taken, payload word expected
    } dec_state_e;
endpackage

// File: rtl/esc_dec_fsm.sv
// Sequence tracker: recognises escape and control words, drives both
// handshakes, and latches the last flag and received checksum.
// Assumes the upstream keeps a word stable while it waits for in_ready.
module esc_dec_fsm
    import esc_dec_pkg::*;
#(
    parameter int              DATA_W   = 64,
    parameter logic [DATA_W-1:0] ESC_WORD = 64'hDEADBEEFFEEDCAFE,
    localparam int             HALF_W   = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              fwd,
    output logic              fwd_last,
    output logic [HALF_W-1:0] rx_sum,
    output dec_state_e        state
);
    dec_state_e        nxt;
    logic              is_esc;
    logic              last_q;
    logic [HALF_W-1:0] rx_sum_q;

    assign is_esc = (in_data == ESC_WORD);

    // Handshake decode per state.
    always_comb begin
        in_ready  = out_ready;
        out_valid = 1'b0;
        nxt       = state;
        unique case (state)
            ST_CTRL: begin
                in_ready = 1'b1;
                if (in_valid) nxt = ST_LOAD;
            end
            ST_LOAD: begin
                out_valid = in_valid;
                if (in_valid && out_ready) nxt = ST_PASS;
            end
            default: begin
                out_valid = in_valid && !is_esc;
                in_ready  = is_esc ? 1'b1 : out_ready;
                if (in_valid && is_esc) nxt = ST_CTRL;
            end
        endcase
    end

    assign fwd      = out_valid && out_ready;
    assign fwd_last = (state == ST_LOAD) && last_q;
    assign rx_sum   = rx_sum_q;

    // State register with reset and clear to pass-through.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) state <= ST_PASS;
        else               state <= nxt;
    end

    // Capture the control word fields as the control word is taken.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            last_q   <= 1'b0;
            rx_sum_q <= '0;
        end else if (state == ST_CTRL && in_valid) begin
            last_q   <= in_data[0];
            rx_sum_q <= in_data[DATA_W-1:HALF_W];
        end
    end
endmodule

// File: rtl/esc_dec_csum.sv
// Running packet checksum: wrapping sum of both halves of each
// forwarded non-last word, zeroed after a last word, reset or clear.
module esc_dec_csum #(
    parameter int HALF_W = 32,
    localparam int DATA_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              beat,
    input  logic              beat_last,
    input  logic [DATA_W-1:0] word,
    input  logic [HALF_W-1:0] rx_sum,
    output logic              mismatch
);
    logic [HALF_W-1:0] acc;

    // Accumulate payload halves; restart after each packet end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)          acc <= '0;
        else if (beat && beat_last) acc <= '0;
        else if (beat)              acc <= acc + word[HALF_W-1:0] + word[DATA_W-1:HALF_W];
    end

    assign mismatch = (rx_sum != acc);
endmodule

// File: rtl/esc_tlast_decoder.sv
// Top of the in-band end-of-packet escape decoder. Ties the sequence
// tracker to the checksum unit; data passes combinationally.
// Assumes well-formed escape sequences on the input.
module esc_tlast_decoder
    import esc_dec_pkg::*;
#(
    parameter int              DATA_W   = 64,
    parameter logic [DATA_W-1:0] ESC_WORD = 64'hDEADBEEFFEEDCAFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sum_err
);
    localparam int HALF_W = DATA_W / 2;

    dec_state_e        cur_state;
    logic              fwd;
    logic              fwd_last;
    logic              mismatch;
    logic [HALF_W-1:0] rx_sum;

    esc_dec_fsm #(.DATA_W(DATA_W), .ESC_WORD(ESC_WORD)) u_fsm (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready),
        .fwd(fwd), .fwd_last(fwd_last), .rx_sum(rx_sum), .state(cur_state)
    );

    esc_dec_csum #(.HALF_W(HALF_W)) u_csum (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .beat(fwd), .beat_last(fwd_last), .word(in_data),
        .rx_sum(rx_sum), .mismatch(mismatch)
    );

    assign out_data    = in_data;
    assign out_last    = fwd_last;
    assign out_sum_err = out_valid && fwd_last && mismatch;
endmodule

// File: rtl/esc_tlast_decoder_chk.sv
// Property checker for the escape decoder, bound to the top module.
// Assumes the upstream holds words stable while stalled.
module esc_tlast_decoder_chk
    import esc_dec_pkg::*;
#(
    parameter int              DATA_W   = 64,
    parameter logic [DATA_W-1:0] ESC_WORD = 64'hDEADBEEFFEEDCAFE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic [DATA_W-1:0] in_data,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_last,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_sum_err,
    input dec_state_e        cur_state
);
    a_r1_clear_to_pass: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cur_state == ST_PASS);

    a_r2_plain_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_PASS && in_valid && in_data != ESC_WORD) |-> (out_valid && !out_last));

    a_r3_escape_swallowed: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_PASS && in_valid && in_data == ESC_WORD) |-> (in_ready && !out_valid));

    a_r3_ctrl_swallowed: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_CTRL) |-> (in_ready && !out_valid));

    a_r4_payload_follows: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (cur_state == ST_CTRL && in_valid) |=> (cur_state == ST_LOAD));

    a_r6_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (in_ready == out_ready));

    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    a_r7_err_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_sum_err |-> (out_valid && out_last));
endmodule

bind esc_tlast_decoder esc_tlast_decoder_chk #(.DATA_W(DATA_W), .ESC_WORD(ESC_WORD)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_last(out_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_sum_err(out_sum_err),
    .cur_state(cur_state)
);

// File: tb/esc_tlast_decoder_tb.sv
// Self-checking bench: directed corner cases, then random packets
// encoded in the bench and decoded under random stalls on both sides.
module esc_tlast_decoder_tb;
    localparam logic [63:0] ESC = 64'hDEADBEEFFEEDCAFE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [63:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] out_data;
    logic        out_last;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        out_sum_err;

    int checks = 0;
    int fails  = 0;

    // Encoded input stream and expected decoded stream.
    logic [63:0] in_q[$];
    int          kind_q[$];   // 0 plain, 1 escape, 2 control, 3 payload
    logic [63:0] exp_d[$];
    bit          exp_l[$];
    bit          exp_e[$];

    esc_tlast_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
        .out_last(out_last), .out_valid(out_valid), .out_ready(out_ready),
        .out_sum_err(out_sum_err)
    );

    always #5 clk = ~clk;

    // Record one check result.
    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Checksum contribution of one word.
    function automatic logic [31:0] half_sum(input logic [63:0] w);
        return w[31:0] + w[63:32];
    endfunction

    // Present one word for a cycle and check the outputs before the edge.
    task automatic beat(input logic [63:0] w, input bit ev, input bit el, input bit ee, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        #4;
        chk(out_valid == ev, req, 64'(out_valid), 64'(ev));
        if (ev) begin
            chk(out_data == w, req, out_data, w);
            chk(out_last == el, req, 64'(out_last), 64'(el));
            chk(out_sum_err == ee, req, 64'(out_sum_err), 64'(ee));
        end else begin
            chk(in_ready == 1'b1, req, 64'(in_ready), 64'd1);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    // Encode one random packet into the stream and expected queues.
    task automatic encode_pkt(input int len, input bit corrupt);
        logic [31:0] s = '0;
        for (int i = 0; i < len; i++) begin
            logic [63:0] w = ($urandom % 5 == 0) ? ESC : {$urandom, $urandom};
            if (i == len - 1) begin
                in_q.push_back(ESC);  kind_q.push_back(1);
                in_q.push_back({s ^ (corrupt ? 32'h0000_0100 : 32'h0), 32'h1}); kind_q.push_back(2);
                in_q.push_back(w);    kind_q.push_back(3);
                exp_d.push_back(w); exp_l.push_back(1'b1); exp_e.push_back(corrupt);
            end else begin
                if (w == ESC) begin
                    in_q.push_back(ESC);  kind_q.push_back(1);
                    in_q.push_back(64'h0); kind_q.push_back(2);
                    in_q.push_back(w);    kind_q.push_back(3);
                end else begin
                    in_q.push_back(w);    kind_q.push_back(0);
                end
                exp_d.push_back(w); exp_l.push_back(1'b0); exp_e.push_back(1'b0);
                s = s + half_sum(w);
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1_500_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] d;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset
        #4;
        chk(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R1", 64'(in_ready), 64'd1);

        beat(64'h0123_4567_89AB_CDEF, 1, 0, 0, "R2");
        beat(ESC, 0, 0, 0, "R3");
        pulse_clr();
        beat(64'h1111_2222_3333_4444, 1, 0, 0, "R9");

        // R1/R8: a clear zeros the running sum before a last word
        pulse_clr();
        beat(ESC, 0, 0, 0, "R3");
        beat({32'h0, 32'h1}, 0, 0, 0, "R3");
        beat(64'h5555_0000_0000_0001, 1, 1, 0, "R8");

        // R8: sum restarts after a last word, then accumulates
        d = 64'h0000_0010_0000_0020;
        beat(d, 1, 0, 0, "R2");
        beat(ESC, 0, 0, 0, "R3");
        beat({half_sum(d), 32'h1}, 0, 0, 0, "R3");
        beat(64'h7777_8888_9999_AAAA, 1, 1, 0, "R7");

        // R7: mismatching checksum flagged
        beat(64'h0000_0001_0000_0001, 1, 0, 0, "R2");
        beat(ESC, 0, 0, 0, "R3");
        beat({32'h0000_0005, 32'h1}, 0, 0, 0, "R3");
        beat(64'hABCD_0000_0000_1234, 1, 1, 1, "R7");

        // R5: escape-valued data, not last, then last
        beat(ESC, 0, 0, 0, "R3");
        beat(64'h0, 0, 0, 0, "R3");
        beat(ESC, 1, 0, 0, "R5");
        beat(ESC, 0, 0, 0, "R3");
        beat({half_sum(ESC), 32'h1}, 0, 0, 0, "R3");
        beat(ESC, 1, 1, 0, "R5");

        // Random phase with stalls on both sides.
        for (int p = 0; p < 250; p++)
            encode_pkt(1 + int'($urandom % 6), ($urandom % 4) == 0);
        begin
            int  ip = 0;
            int  op = 0;
            bit  pend = 0;
            bit  held = 0;
            logic [63:0] hd = '0;
            bit  hl = 0;
            while (op < exp_d.size()) begin
                @(negedge clk);
                if (!pend) begin
                    if (ip < in_q.size() && ($urandom % 4) != 0) begin
                        in_valid = 1'b1;
                        in_data  = in_q[ip];
                        pend     = 1'b1;
                    end else begin
                        in_valid = 1'b0;
                    end
                end
                out_ready = ($urandom % 3) != 0;
                #4;
                if (in_valid && (kind_q[ip] == 1 || kind_q[ip] == 2))
                    chk(in_ready && !out_valid, "R3", {in_ready, out_valid}, 64'h2);
                if (out_valid)
                    chk(in_ready == out_ready, "R6", 64'(in_ready), 64'(out_ready));
                if (held) begin
                    chk(out_valid && out_data == hd, "R6", out_data, hd);
                    chk(out_last == hl, "R6", 64'(out_last), 64'(hl));
                end
                if (out_valid && out_ready) begin
                    string tg = exp_l[op] ? "R4" : ((exp_d[op] == ESC) ? "R5" : "R2");
                    chk(out_data == exp_d[op], tg, out_data, exp_d[op]);
                    chk(out_last == exp_l[op], tg, 64'(out_last), 64'(exp_l[op]));
                    chk(out_sum_err == exp_e[op], "R7", 64'(out_sum_err), 64'(exp_e[op]));
                    op++;
                end
                held = out_valid && !out_ready;
                hd   = out_data;
                hl   = out_last;
                if (in_valid && in_ready) begin
                    ip++;
                    pend = 1'b0;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule